// File: doc/BRIEF.md
# Interleaved Accumulation Scheduler for a Binarized Dense Layer

This block computes one fully connected layer of a binarized network using a single adder with a long pipeline. The adder plus its result register form a feedback loop of `L` cycles. The block therefore works on `L` neurons at a time, a "group". Each cycle it starts one addition for the next neuron of the group, and it keeps each neuron's running total in its own slot of a small register file. Every neuron's slot comes back round exactly when its previous addition has left the pipeline, so the adder does useful work on every cycle of a layer.

The block generates a term index and a node index. Input pixels or previous-layer activations, weight bits and biases are read combinationally over ports. An input term is held steady for `L` cycles and shared by the whole group.

- **Input-layer mode:** an 8-bit unsigned pixel is either added or subtracted, as chosen by its weight bit.
- **Hidden-layer mode:** the activation bit and the weight bit are XNORed. Each term counts +2 on a match and 0 on a mismatch, and the bias pass subtracts the term count. The result equals a sum of ±1 terms.

After the last term, each neuron goes once more through the adder with its bias. The sign of that final sum gives the binary activation, which is emitted in node order.

The controller has four states:
- **IDLE:** waits for `start`.
- **TERM:** issues weighted terms.
- **BIAS:** issues the bias pass of a group.
- **DRAIN:** waits for the last results.

Its transitions:
- IDLE→TERM on `start`.
- TERM→BIAS after the last slot of the last term.
- BIAS→TERM after the last slot when more groups remain.
- BIAS→DRAIN after the last slot of the last group.
- DRAIN→IDLE when `done` is high.

Top module: `ilacc_layer`

## Requirements
- R1: After reset, `busy`, `done` and `act_valid` are all 0.
- R2: A `start` pulse in IDLE starts a layer and latches `hidden_mode`. `busy` stays 1 from the next cycle until the cycle after `done`. A `start` pulse while busy is ignored, including the `hidden_mode` value that comes with it.
- R3: Issue order: the slot counter runs fastest. `node_idx` equals group·L + slot. `term_idx` stays fixed for L consecutive cycles and then steps from 0 to N_TERMS−1. The first L·N_TERMS issue cycles after the start edge carry term k/L for node k mod L.
- R4: In input mode (`hidden_mode`=0), a weight bit of 1 adds the zero-extended pixel and a weight bit of 0 adds its 9-bit two's complement, so an all-255 pixel row gives ±255·N_TERMS.
- R5: In hidden mode (`hidden_mode`=1), each term contributes +1 when `act_data` equals `w_bit` and −1 otherwise, taken over all N_TERMS terms.
- R6: Each neuron's `bias_data`, read while `node_idx` addresses that neuron during the bias pass, is added exactly once to its weighted sum.
- R7: `act_out` is 1 when the final sum (weighted sum + bias) is zero or positive, and 0 when it is negative.
- R8: Exactly one `act_valid` pulse appears per neuron, with `act_node` rising from 0 to N_NODES−1.
- R9: `done` is high in the same cycle as the `act_valid` pulse of neuron N_NODES−1, and only then.
- R10: With the start edge counted as edge 0, `done` becomes visible after edge N_NODES·(N_TERMS+1)+L−1. This is one addition per cycle plus one loop drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a layer (honoured in IDLE only) |
| hidden_mode | input | 1 | 0 = pixel inputs, 1 = binary activation inputs |
| busy | output | 1 | Layer in progress |
| done | output | 1 | Pulses with the last activation |
| node_idx | output | $clog2(N_NODES) | Neuron addressed for weight and bias |
| term_idx | output | $clog2(N_TERMS) | Input term addressed |
| pix_data | input | PIX_W | Unsigned pixel at `term_idx` |
| act_data | input | 1 | Previous-layer activation at `term_idx` |
| w_bit | input | 1 | Weight bit at (`node_idx`, `term_idx`) |
| bias_data | input | SUM_W | Signed bias at `node_idx` |
| act_valid | output | 1 | An activation is presented |
| act_node | output | $clog2(N_NODES) | Neuron of the activation |
| act_out | output | 1 | Binary activation |

## Verification
In input mode, random pixels and weights show that the add and subtract paths are chosen per node and per term. An all-255 row with uniform weights exercises the largest two's complement values. Biases set to the exact negative of each weighted sum plus 0, −1 or +1 separate a correct zero-is-positive sign decision from an off-by-one or an inverted sign. Hidden mode is run with random and with boundary biases: this separates XNOR from XOR polarity and shows whether the term count is subtracted. A second `start` sent mid-layer with the opposite mode shows that no state or latched mode is disturbed.

// File: rtl/ilacc_pkg.sv
package ilacc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TERM  = 2'd1,
        ST_BIAS  = 2'd2,
        ST_DRAIN = 2'd3
    } ilacc_state_e;
endpackage

// File: rtl/ilacc_term_sel.sv
// Forms one signed addend from a pixel or a binary activation and a weight bit.
module ilacc_term_sel #(
    parameter int PIX_W = 8,
    parameter int SUM_W = 16
) (
    input  logic                    hidden,
    input  logic [PIX_W-1:0]        pix,
    input  logic                    act,
    input  logic                    wbit,
    output logic signed [SUM_W-1:0] term
);
    logic signed [PIX_W:0] pos_v;
    logic signed [PIX_W:0] sel_v;

    always_comb begin
        pos_v = {1'b0, pix};
        sel_v = wbit ? pos_v : -pos_v;
        if (hidden) begin
            // match counts 2, mismatch 0; the bias pass removes N_TERMS
            term = (act ~^ wbit) ? SUM_W'(2) : '0;
        end else begin
            term = {{(SUM_W-PIX_W-1){sel_v[PIX_W]}}, sel_v};
        end
    end
endmodule

// File: rtl/ilacc_adder_pipe.sv
// Latency model of the shared adder: the sum enters at stage 0 and emerges DEPTH stages later.
module ilacc_adder_pipe #(
    parameter int SUM_W = 16,
    parameter int TAG_W = 8,
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [TAG_W-1:0]        in_tag,
    input  logic signed [SUM_W-1:0] op_a,
    input  logic signed [SUM_W-1:0] op_b,
    output logic                    out_vld,
    output logic [TAG_W-1:0]        out_tag,
    output logic signed [SUM_W-1:0] out_sum
);
    logic                    vld_q [DEPTH];
    logic [TAG_W-1:0]        tag_q [DEPTH];
    logic signed [SUM_W-1:0] sum_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
                sum_q[i] <= '0;
            end
        end else begin
            vld_q[0] <= in_vld;
            tag_q[0] <= in_tag;
            sum_q[0] <= op_a + op_b;
            for (int i = 1; i < DEPTH; i++) begin
                vld_q[i] <= vld_q[i-1];
                tag_q[i] <= tag_q[i-1];
                sum_q[i] <= sum_q[i-1];
            end
        end
    end

    assign out_vld = vld_q[DEPTH-1];
    assign out_tag = tag_q[DEPTH-1];
    assign out_sum = sum_q[DEPTH-1];
endmodule

// File: rtl/ilacc_psum_rf.sv
// One partial-sum slot per interleaved neuron.
module ilacc_psum_rf #(
    parameter int SUM_W = 16,
    parameter int L     = 5,
    localparam int SLW  = $clog2(L)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SLW-1:0]          rd_idx,
    output logic signed [SUM_W-1:0] rd_data,
    input  logic                    wr_en,
    input  logic [SLW-1:0]          wr_idx,
    input  logic signed [SUM_W-1:0] wr_data
);
    logic signed [SUM_W-1:0] slots [L];

    for (genvar i = 0; i < L; i++) begin : g_slot
        logic signed [SUM_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_idx == SLW'(i)) begin
                q <= wr_data;
            end
        end
        assign slots[i] = q;
    end

    assign rd_data = slots[rd_idx];
endmodule

// File: rtl/ilacc_layer.sv
module ilacc_layer #(
    parameter int L       = 5,
    parameter int N_NODES = 10,
    parameter int N_TERMS = 4,
    parameter int PIX_W   = 8,
    parameter int SUM_W   = 16,
    localparam int N_GROUPS = N_NODES / L,
    localparam int SLW      = $clog2(L),
    localparam int NIW      = $clog2(N_NODES),
    localparam int TIW      = (N_TERMS > 1) ? $clog2(N_TERMS) : 1,
    localparam int GW       = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1,
    localparam int TAG_W    = 1 + SLW + NIW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    hidden_mode,
    output logic                    busy,
    output logic                    done,
    output logic [NIW-1:0]          node_idx,
    output logic [TIW-1:0]          term_idx,
    input  logic [PIX_W-1:0]        pix_data,
    input  logic                    act_data,
    input  logic                    w_bit,
    input  logic signed [SUM_W-1:0] bias_data,
    output logic                    act_valid,
    output logic [NIW-1:0]          act_node,
    output logic                    act_out
);
    import ilacc_pkg::*;

    ilacc_state_e state_q, state_d;
    logic            mode_q;
    logic [SLW-1:0]  slot_q;
    logic [TIW-1:0]  term_q;
    logic [GW-1:0]   group_q;

    logic slot_last, term_last, group_last;
    logic issue, fin;
    logic signed [SUM_W-1:0] op_a, op_b, term_val, rf_rd, bias_adj;
    logic                    out_vld;
    logic [TAG_W-1:0]        out_tag;
    logic signed [SUM_W-1:0] out_sum;

    assign slot_last  = (slot_q == SLW'(L-1));
    assign term_last  = (term_q == TIW'(N_TERMS-1));
    assign group_last = (group_q == GW'(N_GROUPS-1));
    assign node_idx   = NIW'(group_q) * NIW'(L) + NIW'(slot_q);
    assign term_idx   = term_q;
    assign busy       = (state_q != ST_IDLE);
    assign done       = act_valid && (act_node == NIW'(N_NODES-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_TERM;
            ST_TERM:  if (slot_last && term_last) state_d = ST_BIAS;
            ST_BIAS:  if (slot_last) state_d = group_last ? ST_DRAIN : ST_TERM;
            ST_DRAIN: if (done) state_d = ST_IDLE;
        endcase
    end

    // schedule counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            slot_q  <= '0;
            term_q  <= '0;
            group_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    mode_q  <= hidden_mode;
                    slot_q  <= '0;
                    term_q  <= '0;
                    group_q <= '0;
                end
                ST_TERM: if (slot_last) begin
                    slot_q <= '0;
                    term_q <= term_last ? '0 : term_q + TIW'(1);
                end else begin
                    slot_q <= slot_q + SLW'(1);
                end
                ST_BIAS: if (slot_last) begin
                    slot_q  <= '0;
                    group_q <= group_q + GW'(1);
                end else begin
                    slot_q <= slot_q + SLW'(1);
                end
                ST_DRAIN: ;
            endcase
        end
    end

    ilacc_term_sel #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_term (
        .hidden (mode_q),
        .pix    (pix_data),
        .act    (act_data),
        .wbit   (w_bit),
        .term   (term_val)
    );

    assign bias_adj = bias_data - (mode_q ? SUM_W'(N_TERMS) : '0);

    // issue outputs
    always_comb begin
        issue = 1'b0;
        fin   = 1'b0;
        op_a  = rf_rd;
        op_b  = term_val;
        unique case (state_q)
            ST_IDLE, ST_DRAIN: ;
            ST_TERM: begin
                issue = 1'b1;
                if (term_q == '0) op_a = '0;   // fresh slot for a new group
            end
            ST_BIAS: begin
                issue = 1'b1;
                fin   = 1'b1;
                op_b  = bias_adj;
            end
        endcase
    end

    ilacc_adder_pipe #(.SUM_W(SUM_W), .TAG_W(TAG_W), .DEPTH(L-1)) u_add (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (issue),
        .in_tag  ({fin, slot_q, node_idx}),
        .op_a    (op_a),
        .op_b    (op_b),
        .out_vld (out_vld),
        .out_tag (out_tag),
        .out_sum (out_sum)
    );

    // accumulator register closes the loop: write-back and activation share this edge
    ilacc_psum_rf #(.SUM_W(SUM_W), .L(L)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (slot_q),
        .rd_data (rf_rd),
        .wr_en   (out_vld),
        .wr_idx  (out_tag[NIW +: SLW]),
        .wr_data (out_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_valid <= 1'b0;
            act_node  <= '0;
            act_out   <= 1'b0;
        end else begin
            act_valid <= out_vld && out_tag[TAG_W-1];
            act_node  <= out_tag[NIW-1:0];
            act_out   <= ~out_sum[SUM_W-1];
        end
    end

    // R3: one input term is shared by the whole group
    a_r3_term_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TERM && slot_q != '0) |-> $stable(term_idx));

    // R8: activations leave in ascending node order
    a_r8_node_order: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |=> (!act_valid || act_node == $past(act_node) + NIW'(1)));

    // R9: done ends the layer
    a_r9_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R2: busy never drops before done
    a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/ilacc_layer_tb_top.sv
`timescale 1ns/1ps
module ilacc_layer_tb_top;
    localparam int L = 5, NN = 10, NT = 4;
    localparam int LAT = NN * (NT + 1) + L - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic hidden_mode = 1'b0;
    logic busy, done, act_valid, act_out;
    logic [3:0] node_idx, act_node;
    logic [1:0] term_idx;
    logic [7:0] pix_data;
    logic act_data, w_bit;
    logic signed [15:0] bias_data;

    logic [7:0]         pix_m  [NT];
    logic               act_m  [NT];
    logic               w_m    [NN][NT];
    logic signed [15:0] bias_m [NN];

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    assign pix_data  = pix_m[term_idx];
    assign act_data  = act_m[term_idx];
    assign w_bit     = w_m[node_idx][term_idx];
    assign bias_data = bias_m[node_idx];

    ilacc_layer #(.L(L), .N_NODES(NN), .N_TERMS(NT), .PIX_W(8), .SUM_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .hidden_mode(hidden_mode),
        .busy(busy), .done(done), .node_idx(node_idx), .term_idx(term_idx),
        .pix_data(pix_data), .act_data(act_data), .w_bit(w_bit), .bias_data(bias_data),
        .act_valid(act_valid), .act_node(act_node), .act_out(act_out)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic int ref_sum(input int n, input bit m);
        int s = 0;
        for (int t = 0; t < NT; t++) begin
            if (m) s += (act_m[t] == w_m[n][t]) ? 1 : -1;
            else   s += w_m[n][t] ? int'(pix_m[t]) : -int'(pix_m[t]);
        end
        return s;
    endfunction

    // kind 0: random, 1: bias at the sign boundary, 2: extreme pixels
    task automatic fill(input bit m, input int kind);
        for (int t = 0; t < NT; t++) begin
            pix_m[t] = (kind == 2) ? 8'd255 : 8'($urandom_range(0, 255));
            act_m[t] = 1'($urandom_range(0, 1));
        end
        for (int n = 0; n < NN; n++) begin
            for (int t = 0; t < NT; t++)
                w_m[n][t] = (kind == 2) ? n[0] : 1'($urandom_range(0, 1));
            if (kind == 0)
                bias_m[n] = m ? 16'(int'($urandom_range(0, 6)) - 3)
                              : 16'(int'($urandom_range(0, 1200)) - 600);
            else if (kind == 1)
                bias_m[n] = 16'(-ref_sum(n, m) + ((n % 3 == 1) ? -1 : (n % 3 == 2) ? 1 : 0));
            else
                bias_m[n] = 16'(-ref_sum(n, m) - ((n % 4 >= 2) ? 1 : 0));
        end
    endtask

    // runs one layer and checks R2, R3, R8, R9, R10 and every activation under tag req
    task automatic run_layer(input bit m, input bit restart, input string req);
        int  seen = 0;
        int  done_edge = -1;
        bit  order_ok = 1'b1;
        bit  issue_ok = 1'b1;
        bit  got [NN];
        int  got_at [NN];
        for (int n = 0; n < NN; n++) got_at[n] = -1;
        @(negedge clk);
        hidden_mode = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int e = 0; e <= LAT + 2; e++) begin
            if (e < NT * L)
                if (int'(term_idx) != e / L || int'(node_idx) != e % L) issue_ok = 1'b0;
            if (act_valid) begin
                if (int'(act_node) != seen) order_ok = 1'b0;
                if (int'(act_node) < NN) begin
                    got[act_node] = act_out;
                    got_at[act_node] = e;
                end
                seen++;
            end
            if (done) done_edge = e;
            if (e == LAT) check(busy == 1'b1, "R2 busy held until done", int'(busy), 1);
            if (e == LAT + 1) check(busy == 1'b0, "R2 busy dropped after done", int'(busy), 0);
            if (restart && e == 7) begin
                start = 1'b1;
                hidden_mode = ~m;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        hidden_mode = m;
        check(issue_ok, "R3 issue order", int'(issue_ok), 1);
        check(order_ok && seen == NN, "R8 one activation per node in order", seen, NN);
        check(done_edge == LAT, "R9/R10 done edge", done_edge, LAT);
        for (int n = 0; n < NN; n++) begin
            int exp_s = ref_sum(n, m) + int'(bias_m[n]);
            int exp_a = (exp_s >= 0) ? 1 : 0;
            check(got_at[n] >= 0 && int'(got[n]) == exp_a,
                  $sformatf("%s R6 R7 node %0d sum %0d", req, n, exp_s), int'(got[n]), exp_a);
        end
    endtask

    task automatic t_reset;
        check(!busy && !done && !act_valid, "R1 reset outputs quiet",
              int'({busy, done, act_valid}), 0);
    endtask

    task automatic t_input_random;
        fill(1'b0, 0);
        run_layer(1'b0, 1'b0, "R4 input random");
    endtask

    task automatic t_input_boundary;
        fill(1'b0, 1);
        run_layer(1'b0, 1'b0, "R4 input boundary");
    endtask

    task automatic t_input_extreme;
        fill(1'b0, 2);
        run_layer(1'b0, 1'b0, "R4 input 255 rows");
    endtask

    task automatic t_hidden_random;
        fill(1'b1, 0);
        run_layer(1'b1, 1'b0, "R5 hidden random");
    endtask

    task automatic t_hidden_boundary;
        fill(1'b1, 1);
        run_layer(1'b1, 1'b0, "R5 hidden boundary");
    endtask

    task automatic t_restart_ignored;
        fill(1'b0, 1);
        run_layer(1'b0, 1'b1, "R2 start while busy");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_input_random();
        t_input_boundary();
        t_input_extreme();
        t_hidden_random();
        t_hidden_boundary();
        t_restart_ignored();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule